// File: doc/BRIEF.md
# NMI Source Aggregation and Routing

This block gathers system fault indications and sixteen general purpose input lines and folds them into one non-maskable interrupt line. Each source is synchronized, watched for its active edge, and recorded in a sticky status bit. A routing choice decides whether each pending bit drives the non-maskable interrupt output or an alternate system control interrupt (SCI) output.

The non-maskable interrupt output is a one-cycle pulse produced only when the combined NMI request goes from low to high. Only one such line exists, and it ranks above any maskable request. The SCI output is a level. Software uses a small register port to set the routing, the parity response enable and the general purpose direction and routing fields. It clears pending bits by writing ones to the status address. A management controller raises an NMI by driving general purpose input 3 once that pin is routed to NMI.

Top module: `nmi_router`

## Requirements
- R1: After reset the status register reads 0, `nmi` and `sci` are 0, the control register (address 0) reads 0, the general purpose routing register (address 2) reads 0 and the direction register (address 3) reads all ones for the sixteen pins (0x0000FFFF).
- R2: Every source passes through two synchronizing flops. A qualifying input edge applied before clock edge E1 sets its status bit at edge E3. The NMI pulse is high between E3 and E4.
- R3: A falling edge on `serr_n` sets status bit 0. It is routed to NMI when control bit 0 is 0 and to SCI when control bit 0 is 1.
- R4: A falling edge on `iochk_n` sets status bit 1. It uses the same control bit 0 routing as R3.
- R5: A rising edge on `par_err` sets status bit 2 only while control bit 1 (parity response enable) is 1. Otherwise it is ignored. Status bit 2 always routes to NMI.
- R6: A rising edge on `gpio_in[n]` sets status bit 3+n only when direction bit n is 1 (input) and routing field bits [2n+1:2n] of address 2 are 2'b10 (NMI) or 2'b01 (SCI). Codes 2'b00 and 2'b11 ignore the pin.
- R7: `nmi` is a single-cycle pulse on each low-to-high transition of the OR of all NMI-routed status bits. A further source that sets while that OR is already high gives no new pulse.
- R8: `sci` is high exactly while at least one SCI-routed status bit is set.
- R9: Writing to address 1 clears each status bit whose write data bit is 1. Bits written 0 keep their value.
- R10: `reg_rdata` shows the register chosen by `reg_addr` in the same cycle: 0 control, 1 status, 2 general purpose routing, 3 direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serr_n | input | 1 | Active-low system error, asynchronous |
| iochk_n | input | 1 | Active-low I/O check error, asynchronous |
| par_err | input | 1 | Secondary parity error status, asynchronous |
| gpio_in | input | 16 | General purpose inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| nmi | output | 1 | Non-maskable interrupt pulse |
| sci | output | 1 | System control interrupt level |

## Verification
The assertions check on every cycle that the NMI pulse lasts one cycle and appears only with an NMI-routed bit pending. They also check that no status bit rises without a detected edge, that a cleared bit drops, that SCI stays low while nothing is pending, and that parity events are ignored while their enable is off. Only the bench scenarios can show the routing choices, the direction gating of general purpose pins, and the absence of a second pulse while the request is already high. They also cover the exact latency through the synchronizers and the register readback.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic [1:0] {
    RT_OFF  = 2'b00,
    RT_SCI  = 2'b01,
    RT_NMI  = 2'b10,
    RT_OFF2 = 2'b11
  } route_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_ROUTE  = 2'd2;
  localparam logic [1:0] A_DIR    = 2'd3;

  localparam int IDX_SERR   = 0;
  localparam int IDX_IOCHK  = 1;
  localparam int IDX_PARITY = 2;
  localparam int IDX_GPIO0  = 3;

  function automatic logic route_is_nmi(input logic [1:0] f);
    return route_e'(f) == RT_NMI;
  endfunction

  function automatic logic route_is_sci(input logic [1:0] f);
    return route_e'(f) == RT_SCI;
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nmi_status.sv
module nmi_status #(
  parameter int N = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] qual,
  input  logic [N-1:0] clr,
  output logic [N-1:0] set_evt,
  output logic [N-1:0] status
);
  logic [N-1:0] prev;

  assign set_evt = lvl & ~prev & qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      status <= '0;
    end else begin
      prev   <= lvl;
      status <= (status & ~clr) | set_evt;
    end
  end

  // R2: a status bit only rises after a detected qualifying edge
  assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(set_evt)) == '0);

  // R9: a cleared bit with no simultaneous event reads 0 next cycle
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & $past(clr & ~set_evt)) == '0);
endmodule

// File: rtl/nmi_pulse.sv
module nmi_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign pulse = req & ~req_q;

  // R7: the pulse lasts exactly one cycle
  assert_nmi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/nmi_router.sv
module nmi_router #(
  parameter int NG = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serr_n,
  input  logic          iochk_n,
  input  logic          par_err,
  input  logic [NG-1:0] gpio_in,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          nmi,
  output logic          sci
);
  import nmi_pkg::*;

  localparam int NS = IDX_GPIO0 + NG;
  localparam int RW = 2 * NG;

  logic            err_to_sci, par_en;
  logic [RW-1:0]   gp_route;
  logic [NG-1:0]   gp_dir;
  logic [NS-1:0]   raw, lvl, qual, clr, set_evt, status;
  logic [NS-1:0]   nmi_mask, sci_mask;
  logic            nmi_req;

  assign raw = {gpio_in, par_err, ~iochk_n, ~serr_n};

  nmi_sync #(.W(NS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  always_comb begin
    qual       = '0;
    nmi_mask   = '0;
    sci_mask   = '0;
    qual[IDX_SERR]       = 1'b1;
    qual[IDX_IOCHK]      = 1'b1;
    qual[IDX_PARITY]     = par_en;
    nmi_mask[IDX_SERR]   = ~err_to_sci;
    nmi_mask[IDX_IOCHK]  = ~err_to_sci;
    nmi_mask[IDX_PARITY] = 1'b1;
    sci_mask[IDX_SERR]   = err_to_sci;
    sci_mask[IDX_IOCHK]  = err_to_sci;
  end

  for (genvar g = 0; g < NG; g++) begin : g_gpio
    logic is_nmi, is_sci;
    assign is_nmi = route_is_nmi(gp_route[2*g +: 2]);
    assign is_sci = route_is_sci(gp_route[2*g +: 2]);
    always_comb begin
      qual_gp[g] = gp_dir[g] & (is_nmi | is_sci);
      nmi_gp[g]  = is_nmi;
      sci_gp[g]  = is_sci;
    end
  end

  logic [NG-1:0] qual_gp, nmi_gp, sci_gp;
  logic [NS-1:0] qual_all, nmi_all, sci_all;

  assign qual_all = {qual_gp, qual[IDX_GPIO0-1:0]};
  assign nmi_all  = {nmi_gp, nmi_mask[IDX_GPIO0-1:0]};
  assign sci_all  = {sci_gp, sci_mask[IDX_GPIO0-1:0]};

  assign clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NS-1:0] : '0;

  nmi_status #(.N(NS)) u_status (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .qual(qual_all), .clr(clr),
    .set_evt(set_evt), .status(status)
  );

  assign nmi_req = |(status & nmi_all);
  assign sci     = |(status & sci_all);

  nmi_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .req(nmi_req), .pulse(nmi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_to_sci <= 1'b0;
      par_en     <= 1'b0;
      gp_route   <= '0;
      gp_dir     <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          err_to_sci <= reg_wdata[0];
          par_en     <= reg_wdata[1];
        end
        A_ROUTE: gp_route <= reg_wdata[RW-1:0];
        A_DIR:   gp_dir   <= reg_wdata[NG-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[1:0]    = {par_en, err_to_sci};
      A_STATUS: reg_rdata[NS-1:0] = status;
      A_ROUTE:  reg_rdata[RW-1:0] = gp_route;
      default:  reg_rdata[NG-1:0] = gp_dir;
    endcase
  end

  // R7: a pulse only appears while an NMI-routed bit is pending
  assert_nmi_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> (status & nmi_all) != '0);

  // R8: nothing pending means SCI low
  assert_sci_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !sci);

  // R5: parity bit cannot become pending while its enable was off
  assert_parity_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(par_en) && !$past(status[IDX_PARITY])) |-> !status[IDX_PARITY]);
endmodule

// File: tb/nmi_router_tb.sv
module nmi_router_tb;
  localparam int NG = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          serr_n = 1'b1, iochk_n = 1'b1, par_err = 1'b0;
  logic [NG-1:0] gpio_in = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd1;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          nmi, sci;

  always #2 clk = ~clk;

  nmi_router #(.NG(NG), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .serr_n(serr_n), .iochk_n(iochk_n),
    .par_err(par_err), .gpio_in(gpio_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi(nmi), .sci(sci)
  );

  typedef struct {
    string       tag;
    int          sel;   // 0 rdata, 1 sci, 2 nmi pulse count
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0, nmi_cnt = 0, cyc = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && nmi === 1'b1) nmi_cnt++;

  // monitor: pops and compares
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = reg_rdata;
        1:       act = {31'd0, sci};
        default: act = nmi_cnt;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_v(string tag, int sel, logic [31:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
    @(negedge clk); #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] e);
    @(negedge clk);
    reg_addr = a;
    expect_v(tag, 0, e);
    reg_addr = 2'd1;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 status", 2'd1, 32'h0);
    rd("R1 ctrl", 2'd0, 32'h0);
    rd("R1 route", 2'd2, 32'h0);
    rd("R1 dir", 2'd3, 32'h0000FFFF);
    expect_v("R1 sci", 1, 0);
    expect_v("R1 nmi", 2, 0);

    // R2 latency: drive before E1, status set at E3, pulse E3..E4
    @(negedge clk);
    serr_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    expect_v("R2 status before third edge", 0, 32'h0);
    settle();
    // R3 serr to NMI
    expect_v("R3 serr status", 0, 32'h1);
    expect_v("R3 serr nmi", 2, 1);
    // R9 clear
    wr(2'd1, 32'h1);
    settle();
    expect_v("R9 cleared", 0, 32'h0);
    expect_v("R7 no pulse on clear", 2, 1);
    serr_n = 1'b1; settle();

    // R3 serr to SCI
    wr(2'd0, 32'h1);
    serr_n = 1'b0; settle();
    expect_v("R3 serr sci status", 0, 32'h1);
    expect_v("R8 sci high", 1, 1);
    expect_v("R3 no nmi when sci", 2, 1);
    wr(2'd1, 32'h1); settle();
    expect_v("R8 sci low after clear", 1, 0);
    serr_n = 1'b1; settle();

    // R4 iochk to SCI then NMI
    iochk_n = 1'b0; settle();
    expect_v("R4 iochk status", 0, 32'h2);
    expect_v("R4 iochk sci", 1, 1);
    wr(2'd1, 32'h2);
    iochk_n = 1'b1;
    wr(2'd0, 32'h0); settle();
    iochk_n = 1'b0; settle();
    expect_v("R4 iochk nmi", 2, 2);
    expect_v("R8 sci low with nmi route", 1, 0);
    wr(2'd1, 32'h2); iochk_n = 1'b1; settle();

    // R5 parity ignored, then enabled
    par_err = 1'b1; settle();
    expect_v("R5 parity ignored status", 0, 32'h0);
    expect_v("R5 parity ignored nmi", 2, 2);
    par_err = 1'b0;
    wr(2'd0, 32'h2); settle();
    rd("R10 ctrl readback", 2'd0, 32'h2);
    par_err = 1'b1; settle();
    expect_v("R5 parity status", 0, 32'h4);
    expect_v("R5 parity nmi", 2, 3);

    // R6/R7 gpio3 to NMI while parity still pending: no new pulse
    wr(2'd2, 32'h80);
    gpio_in[3] = 1'b1; settle();
    expect_v("R6 gpio3 status", 0, 32'h44);
    expect_v("R7 no second pulse", 2, 3);
    wr(2'd1, 32'h44);
    gpio_in[3] = 1'b0; par_err = 1'b0; settle();
    gpio_in[3] = 1'b1; settle();
    expect_v("R6 gpio3 nmi", 2, 4);
    wr(2'd1, 32'h40); gpio_in[3] = 1'b0; settle();

    // R6 gpio5 routed NMI but configured as output
    wr(2'd2, 32'h880);
    wr(2'd3, 32'hFFDF);
    rd("R10 route readback", 2'd2, 32'h880);
    gpio_in[5] = 1'b1; settle();
    expect_v("R6 gpio5 output ignored", 0, 32'h0);
    expect_v("R6 gpio5 no nmi", 2, 4);
    gpio_in[5] = 1'b0;

    // R6 gpio7 route off, then SCI
    gpio_in[7] = 1'b1; settle();
    expect_v("R6 gpio7 off ignored", 0, 32'h0);
    gpio_in[7] = 1'b0;
    wr(2'd2, 32'h4880); settle();
    gpio_in[7] = 1'b1; settle();
    expect_v("R6 gpio7 sci status", 0, 32'h400);
    expect_v("R8 gpio7 sci", 1, 1);
    expect_v("R6 gpio7 no nmi", 2, 4);
    wr(2'd1, 32'h400); settle();
    expect_v("R8 sci dropped", 1, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule